// File: doc/BRIEF.md
# Dual-Length Serial Configuration Register for a 16-Channel LED Driver

This block is the serial front end of a sixteen-channel LED sink driver. A host streams configuration bits in on `sdi`, one bit per `shift_en` strobe, with the most significant bit first. A mode input picks the target of the next transfer. In brightness mode the chain is 192 bits long, twelve bits per channel. In current-trim mode it is 96 bits long, six bits per channel. A level-sensitive latch input copies the chain into the selected holding register. `sdo` always presents the far end of the active chain, so several drivers can be cascaded by wiring one `sdo` to the next `sdi`.

When a brightness transfer ends, that is when the latch input goes low again, the chain is refilled with a status word. The word carries the sixteen open-LED flags and the over-temperature flag, sampled at that falling edge. The host then clocks the status word out while it shifts the next frame in. The first brightness transfer after a trim transfer behaves differently. The brightness register is committed only by one extra strobe after the latch pulse. That strobe does not shift the chain; it loads the chain with the status word.

All activity runs on the system clock `clk`. `shift_en` stands for a rising edge of the serial clock, already brought into that clock domain.

Top module: `ledcfg_serial_reg`

## Requirements
- R1: The chain shifts left by one bit on each `shift_en` strobe, taking in `sdi`. After 192 strobes in brightness mode, the first bit shifted in sits at `gray_q[191]`. Channel k occupies `gray_q[12k+11:12k]`, so channel 15's word is sent first.
- R2: With `dot_mode`=1 the active chain is 96 bits, and `sdo` shows the bit that was shifted in 96 strobes earlier.
- R3: With `dot_mode`=0 the active chain is 192 bits, and `sdo` shows the bit that was shifted in 192 strobes earlier, as long as no status reload has occurred since.
- R4: While `latch` is high, the selected register takes the chain value on every clock. While `latch` is low, both registers hold, even while the chain shifts.
- R5: A latch pulse with `dot_mode`=1 writes `chain[95:0]` into `dot_q` and leaves `gray_q` unchanged. A pulse with `dot_mode`=0 never writes `dot_q`.
- R6: On the clock in which `latch` falls at the end of a brightness pulse, the chain is loaded with the status word. Bits 191..176 hold `open_flags[15:0]` (bit 191 is `open_flags[15]`), bit 175 holds `therm_flag`, and all lower bits are 0. The word appears on `sdo` most significant bit first.
- R7: The flag values loaded into the status word are the ones present at the falling edge of `latch`. Changes to the flags afterwards do not alter the bits that are shifted out.
- R8: For the first brightness pulse after a trim pulse, `gray_q` keeps its old value through and after the pulse. The next `shift_en` strobe copies the chain into `gray_q` and loads the chain with the status word captured at the falling edge; that strobe shifts nothing.
- R9: After that deferred commit, later brightness pulses update `gray_q` during the pulse, with no extra strobe.
- R10: After reset, `gray_q`, `dot_q` and the chain are all zero, `sdo` is 0, and no deferred commit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial data in |
| shift_en | input | 1 | One-cycle strobe per serial clock rising edge |
| latch | input | 1 | Level-sensitive transfer from the chain to the selected register |
| dot_mode | input | 1 | 1 = current-trim transfer (96 bits), 0 = brightness transfer (192 bits) |
| open_flags | input | 16 | Per-channel open-LED flags, bit k = channel k |
| therm_flag | input | 1 | Over-temperature flag |
| sdo | output | 1 | End of the active chain, for cascading or status readback |
| gray_q | output | 192 | Brightness register, channel k at bits 12k+11:12k |
| dot_q | output | 96 | Current-trim register, channel k at bits 6k+5:6k |

## Verification
Most internal faults reach `sdo` within one strobe. A wrong tap or a wrong shift direction corrupts the serial stream as soon as the chain has filled, 96 or 192 strobes later. A lost or misplaced status reload shows on the first bit read back after the latch falls. A fault in the deferral state (armed by a trim pulse, waiting for the extra strobe) shows in `gray_q` in one of two ways: the register changes a cycle too early during the pulse, or it fails to change on the strobe after the pulse. That makes a cycle-by-cycle comparison of all three outputs against a behavioural model decisive.

// File: rtl/ledcfg_pkg.sv
package ledcfg_pkg;
  localparam int unsigned CH_DEFAULT      = 16;
  localparam int unsigned GRAY_BITS_DEF   = 12;
  localparam int unsigned DOT_BITS_DEF    = 6;

  typedef enum logic {
    MODE_GRAY = 1'b0,
    MODE_DOT  = 1'b1
  } load_mode_e;

  // index of the chain bit presented on the serial output for a given mode
  function automatic int unsigned tap_index(input load_mode_e m,
                                            input int unsigned gray_len,
                                            input int unsigned dot_len);
    return (m == MODE_DOT) ? dot_len - 1 : gray_len - 1;
  endfunction

  // bit position of the thermal flag inside the status word
  function automatic int unsigned therm_pos(input int unsigned gray_len,
                                            input int unsigned ch);
    return gray_len - ch - 1;
  endfunction
endpackage

// File: rtl/ledcfg_shift_chain.sv
module ledcfg_shift_chain
  import ledcfg_pkg::*;
#(
  parameter int unsigned GS_LEN = 192,
  parameter int unsigned DC_LEN = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              sdi,
  input  logic              load_en,
  input  logic [GS_LEN-1:0] load_word,
  input  logic              dot_mode,
  output logic [GS_LEN-1:0] chain_q,
  output logic              sdo
);
  localparam int unsigned IDXW = $clog2(GS_LEN);

  logic [IDXW-1:0] tap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else if (load_en) begin
      chain_q <= load_word;
    end else if (shift_en) begin
      chain_q <= {chain_q[GS_LEN-2:0], sdi};
    end
  end

  always_comb begin
    tap = IDXW'(tap_index(load_mode_e'(dot_mode), GS_LEN, DC_LEN));
    sdo = chain_q[tap];
  end
endmodule

// File: rtl/ledcfg_latch_bank.sv
module ledcfg_latch_bank #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned WORD   = 12,
  localparam int unsigned W     = NUM_CH * WORD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         follow,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[ch*WORD +: WORD] <= '0;
      end else if (follow) begin
        q[ch*WORD +: WORD] <= src[ch*WORD +: WORD];
      end
    end
  end
endmodule

// File: rtl/ledcfg_status_pack.sv
module ledcfg_status_pack
  import ledcfg_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned GS_LEN = 192
) (
  input  logic [NUM_CH-1:0] flags,
  input  logic              therm,
  output logic [GS_LEN-1:0] word
);
  localparam int unsigned TPOS = GS_LEN - NUM_CH - 1;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_flag
    assign word[GS_LEN-1-i] = flags[NUM_CH-1-i];
  end
  assign word[TPOS] = therm;
  assign word[TPOS-1:0] = '0;

  initial begin
    if (therm_pos(GS_LEN, NUM_CH) != TPOS) $error("status layout mismatch");
  end
endmodule

// File: rtl/ledcfg_update_seq.sv
module ledcfg_update_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic latch,
  input  logic dot_mode,
  input  logic shift_en,
  output logic gray_follow,
  output logic dot_follow,
  output logic reload_now,
  output logic commit_now,
  output logic capture_now,
  output logic arm_q,
  output logic wait_q
);
  logic latch_q;
  logic mode_q;
  logic fall_gray;

  always_comb begin
    capture_now = latch_q & ~latch;
    fall_gray   = capture_now & ~mode_q;
    dot_follow  = latch & dot_mode;
    gray_follow = latch & ~dot_mode & ~arm_q;
    reload_now  = fall_gray & ~arm_q;
    commit_now  = wait_q & shift_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      mode_q  <= 1'b0;
      arm_q   <= 1'b0;
      wait_q  <= 1'b0;
    end else begin
      latch_q <= latch;
      mode_q  <= dot_mode;
      if (dot_follow) begin
        arm_q <= 1'b1;
      end else if (fall_gray && arm_q) begin
        arm_q <= 1'b0;
      end
      if (fall_gray && arm_q) begin
        wait_q <= 1'b1;
      end else if (commit_now) begin
        wait_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ledcfg_serial_reg.sv
module ledcfg_serial_reg
  import ledcfg_pkg::*;
#(
  parameter int unsigned NUM_CH    = CH_DEFAULT,
  parameter int unsigned GRAY_BITS = GRAY_BITS_DEF,
  parameter int unsigned DOT_BITS  = DOT_BITS_DEF,
  localparam int unsigned GS_LEN   = NUM_CH * GRAY_BITS,
  localparam int unsigned DC_LEN   = NUM_CH * DOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              shift_en,
  input  logic              latch,
  input  logic              dot_mode,
  input  logic [NUM_CH-1:0] open_flags,
  input  logic              therm_flag,
  output logic              sdo,
  output logic [GS_LEN-1:0] gray_q,
  output logic [DC_LEN-1:0] dot_q
);
  logic              gray_follow_w;
  logic              dot_follow_w;
  logic              reload_w;
  logic              commit_w;
  logic              capture_w;
  logic              arm_w;
  logic              wait_w;
  logic [GS_LEN-1:0] chain_w;
  logic [GS_LEN-1:0] live_word;
  logic [GS_LEN-1:0] held_word;
  logic [GS_LEN-1:0] load_word;
  logic [NUM_CH-1:0] held_flags;
  logic              held_therm;

  ledcfg_update_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch      (latch),
    .dot_mode   (dot_mode),
    .shift_en   (shift_en),
    .gray_follow(gray_follow_w),
    .dot_follow (dot_follow_w),
    .reload_now (reload_w),
    .commit_now (commit_w),
    .capture_now(capture_w),
    .arm_q      (arm_w),
    .wait_q     (wait_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_flags <= '0;
      held_therm <= 1'b0;
    end else if (capture_w) begin
      held_flags <= open_flags;
      held_therm <= therm_flag;
    end
  end

  ledcfg_status_pack #(.NUM_CH(NUM_CH), .GS_LEN(GS_LEN)) u_live_pack (
    .flags(open_flags),
    .therm(therm_flag),
    .word (live_word)
  );

  ledcfg_status_pack #(.NUM_CH(NUM_CH), .GS_LEN(GS_LEN)) u_held_pack (
    .flags(held_flags),
    .therm(held_therm),
    .word (held_word)
  );

  assign load_word = commit_w ? held_word : live_word;

  ledcfg_shift_chain #(.GS_LEN(GS_LEN), .DC_LEN(DC_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .sdi      (sdi),
    .load_en  (reload_w | commit_w),
    .load_word(load_word),
    .dot_mode (dot_mode),
    .chain_q  (chain_w),
    .sdo      (sdo)
  );

  ledcfg_latch_bank #(.NUM_CH(NUM_CH), .WORD(GRAY_BITS)) u_gray (
    .clk   (clk),
    .rst_n (rst_n),
    .follow(gray_follow_w | commit_w),
    .src   (chain_w),
    .q     (gray_q)
  );

  ledcfg_latch_bank #(.NUM_CH(NUM_CH), .WORD(DOT_BITS)) u_dot (
    .clk   (clk),
    .rst_n (rst_n),
    .follow(dot_follow_w),
    .src   (chain_w[DC_LEN-1:0]),
    .q     (dot_q)
  );
endmodule

// File: rtl/ledcfg_checker.sv
module ledcfg_checker #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned GS_LEN = 192,
  parameter int unsigned DC_LEN = 96
) (
  input logic              clk,
  input logic              rst_n,
  input logic              latch,
  input logic              dot_mode,
  input logic              shift_en,
  input logic              sdo,
  input logic [GS_LEN-1:0] gray_q,
  input logic [DC_LEN-1:0] dot_q,
  input logic [GS_LEN-1:0] chain_q,
  input logic              arm_q,
  input logic              wait_q,
  input logic              reload_now
);
  p_dot_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(dot_q));

  p_gray_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch && !wait_q) |=> $stable(gray_q));

  p_trim_skips_gray_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && dot_mode && !wait_q) |=> $stable(gray_q));

  p_status_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload_now |=> (chain_q[GS_LEN-NUM_CH-2:0] == '0));

  p_defer_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !shift_en) |=> $stable(gray_q));

  p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && shift_en) |=> (!wait_q && gray_q == $past(chain_q)));

  p_arm_wait_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |-> !wait_q);

  p_gray_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !dot_mode && !wait_q && !reload_now)
      |=> (dot_mode || sdo == $past(chain_q[GS_LEN-2])));

  p_dot_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && dot_mode && !wait_q && !reload_now)
      |=> (!dot_mode || sdo == $past(chain_q[DC_LEN-2])));
endmodule

bind ledcfg_serial_reg ledcfg_checker #(
  .NUM_CH(NUM_CH), .GS_LEN(GS_LEN), .DC_LEN(DC_LEN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .latch     (latch),
  .dot_mode  (dot_mode),
  .shift_en  (shift_en),
  .sdo       (sdo),
  .gray_q    (gray_q),
  .dot_q     (dot_q),
  .chain_q   (chain_w),
  .arm_q     (arm_w),
  .wait_q    (wait_w),
  .reload_now(reload_w)
);

// File: tb/ledcfg_serial_reg_test.sv
module ledcfg_serial_reg_test;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sdi = 1'b0;
  logic         shift_en = 1'b0;
  logic         latch = 1'b0;
  logic         dot_mode = 1'b0;
  logic [15:0]  open_flags = 16'h0;
  logic         therm_flag = 1'b0;
  logic         sdo;
  logic [191:0] gray_q;
  logic [95:0]  dot_q;

  int checks = 0;
  int errors = 0;
  bit running = 0;

  always #(PERIOD/2) clk = ~clk;

  ledcfg_serial_reg uut (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en), .latch(latch),
    .dot_mode(dot_mode), .open_flags(open_flags), .therm_flag(therm_flag),
    .sdo(sdo), .gray_q(gray_q), .dot_q(dot_q)
  );

  // ---------------- behavioural reference ----------------
  bit           mq[$];        // element 0 = next bit to leave the gray end
  logic [191:0] m_gray;
  logic [95:0]  m_dot;
  int           m_pending;    // 0 none, 1 armed by trim, 2 waiting for extra strobe
  bit           m_lat_prev, m_mode_prev;
  logic [15:0]  m_sflags;
  bit           m_stherm;

  function automatic logic [191:0] model_word();
    logic [191:0] w;
    for (int i = 0; i < 192; i++) w[191-i] = mq[i];
    return w;
  endfunction

  task automatic model_fill(input logic [15:0] f, input bit t);
    mq.delete();
    for (int i = 0; i < 16; i++) mq.push_back(f[15-i]);
    mq.push_back(t);
    for (int i = 17; i < 192; i++) mq.push_back(1'b0);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_fill(16'h0, 1'b0);
      m_gray = '0; m_dot = '0; m_pending = 0;
      m_lat_prev = 0; m_mode_prev = 0; m_sflags = '0; m_stherm = 0;
    end else begin
      logic [191:0] cur;
      bit fell, fell_gray, extra;
      int nxt;
      cur = model_word();
      fell = m_lat_prev && !latch;
      fell_gray = fell && !m_mode_prev;
      extra = (m_pending == 2) && shift_en;
      if (extra) m_gray = cur;
      else if (latch && !dot_mode && m_pending != 1) m_gray = cur;
      if (latch && dot_mode) m_dot = cur[95:0];
      if (extra) model_fill(m_sflags, m_stherm);
      else if (fell_gray && m_pending != 1) model_fill(open_flags, therm_flag);
      else if (shift_en) begin void'(mq.pop_front()); mq.push_back(sdi); end
      nxt = m_pending;
      if (extra) nxt = 0;
      if (fell_gray && m_pending == 1) nxt = 2;
      if (latch && dot_mode) nxt = 1;
      m_pending = nxt;
      if (fell) begin m_sflags = open_flags; m_stherm = therm_flag; end
      m_lat_prev = latch; m_mode_prev = dot_mode;
    end
  end

  task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (running && rst_n) begin
      check("R2 R3 sdo vs model", {191'b0, sdo}, {191'b0, (dot_mode ? mq[96] : mq[0])});
      check("R4 R8 gray vs model", gray_q, m_gray);
      check("R5 dot vs model", {96'b0, dot_q}, {96'b0, m_dot});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input bit sh, input bit b);
    @(negedge clk); #1;
    shift_en = sh; sdi = b;
  endtask

  task automatic idle();
    tick(0, 0);
    @(negedge clk);
  endtask

  task automatic send(input logic [191:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) tick(1, w[i]);
    tick(0, 0);
  endtask

  task automatic pulse_latch();
    @(negedge clk); #1; latch = 1; shift_en = 0;
    @(negedge clk); #1;
    @(negedge clk); #1; latch = 0;
    @(negedge clk);
  endtask

  function automatic logic [191:0] pattern(input int seed);
    logic [191:0] w;
    for (int k = 0; k < 16; k++) w[12*k +: 12] = 12'((k * 273 + seed * 97 + 5) % 4096);
    return w;
  endfunction

  function automatic logic [191:0] status_exp(input logic [15:0] f, input bit t);
    return {f, t, 175'b0};
  endfunction

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [191:0] pa, pb, pc, pe, pf, got;
    logic [95:0]  pd;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    running = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 gray after reset", gray_q, '0);
    check("R10 dot after reset", {96'b0, dot_q}, '0);
    check("R10 sdo after reset", {191'b0, sdo}, '0);

    // R1: first brightness load, no prior trim load
    pa = pattern(1);
    send(pa, 192);
    open_flags = 16'hA5C3; therm_flag = 1;
    pulse_latch();
    for (int k = 0; k < 16; k++)
      check($sformatf("R1 gray channel %0d", k), {180'b0, gray_q[12*k +: 12]},
            {180'b0, 12'((k * 273 + 97 + 5) % 4096)});

    // R6 R7: read back status while new frame goes in; flags change after the fall
    check("R6 first status bit", {191'b0, sdo}, {191'b0, 1'b1});
    open_flags = 16'h0F0F; therm_flag = 0;
    pb = pattern(2);
    got = '0;
    for (int i = 191; i >= 0; i--) begin
      @(negedge clk);
      got[i] = sdo;
      #1 shift_en = 1; sdi = pb[i];
    end
    tick(0, 0);
    check("R6 R7 status readback", got, status_exp(16'hA5C3, 1'b1));
    pulse_latch();
    check("R4 gray follows on plain load", gray_q, pb);

    // R2 R5: trim load
    open_flags = 16'h8001; therm_flag = 1;
    @(negedge clk); #1 dot_mode = 1;
    pd = 96'hC3A5_1E2D_0F96_7B48_5A3C_E1D2;
    send({96'b0, pd}, 96);
    @(negedge clk);
    check("R2 sdo after 96 trim strobes", {191'b0, sdo}, {191'b0, pd[95]});
    pulse_latch();
    check("R5 dot written", {96'b0, dot_q}, {96'b0, pd});
    check("R5 gray untouched by trim", gray_q, pb);

    // R4: shifting with latch low leaves trim register alone
    for (int i = 0; i < 20; i++) tick(1, i[0]);
    tick(0, 0);
    @(negedge clk);
    check("R4 dot holds while shifting", {96'b0, dot_q}, {96'b0, pd});

    // R8: first brightness load after trim needs one extra strobe
    @(negedge clk); #1 dot_mode = 0;
    pc = pattern(3);
    send(pc, 192);
    pulse_latch();
    open_flags = 16'h7777;
    idle();
    check("R8 gray deferred after latch", gray_q, pb);
    tick(1, 1);
    tick(0, 0);
    @(negedge clk);
    check("R8 gray committed on extra strobe", gray_q, pc);
    check("R8 status after extra strobe", {191'b0, sdo}, {191'b0, 1'b1});

    // R9: next brightness load updates at once
    pe = pattern(4);
    send(pe, 192);
    @(negedge clk); #1 latch = 1;
    @(negedge clk); #1;
    @(negedge clk);
    check("R9 gray updates during pulse", gray_q, pe);
    #1 latch = 0;
    idle();

    // R3: brightness chain length 192
    pf = pattern(5);
    send(pf, 192);
    for (int i = 0; i < 3; i++) tick(1, 0);
    tick(0, 0);
    @(negedge clk);
    check("R3 sdo after 195 strobes", {191'b0, sdo}, {191'b0, pf[188]});

    idle();
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule